// File: doc/BRIEF.md
# Shared-Pin GPIO Port with Priority Pin Arbitration

This block is an 8-bit general purpose I/O port whose pins are shared with several peripheral signals: a native CAN controller, a second CAN controller that can be routed onto the port, further CAN receivers, and a routed SPI. Each shared pin has a fixed precedence among the peripherals allowed to claim it. A peripheral claims its pins only while its enable input is high. When no enabled peripheral claims a pin, the pin behaves as plain GPIO.

For every pin the block decides the owner, the pad output value and the pad output enable. It routes the synchronized pad state to the receive input of whichever peripheral owns the pin. Software reaches a data latch, a direction register and a read-only input register over a small register bus. Writes take effect at the clock edge and reads are combinational. All pad inputs pass through a synchronizer before any register read or peripheral sees them.

Top module: `pmux_port`

## Requirements
- R1: After reset the data latch and the direction register are 0. With no peripheral enabled, every `pad_oe` bit is 0 and a direction read (`reg_sel`=1) returns 0.
- R2: A pin with no enabled claimant drives `pad_out` from its data latch bit and `pad_oe` from its direction bit. Pins 2, 6 and 7 are always GPIO. A direction read returns the last value written with `reg_sel`=1.
- R3: A data read (`reg_sel`=0) returns, for each bit, the latch bit where the direction bit is 1 and the synchronized pad bit where it is 0, whoever owns the pin. `reg_sel`=3 reads 0.
- R4: An input read (`reg_sel`=2) returns all 8 synchronized pad bits. These bits equal `pad_in` as sampled two clock edges earlier. Writes to selects 2 and 3 change nothing, and reset does not clear the synchronizer.
- R5: Pin 4 owner, highest first: `can2_en` (receive), `can0r_en` (receive), `can4r_en` (receive), `spi_en` (MOSI), then GPIO.
- R6: Pin 5 owner, highest first: `can1_en` (transmit `can1_tx`), `can0r_en` (transmit `can0r_tx`), `spi_en` (slave select), then GPIO.
- R7: Pin 3 owner, highest first: `can1_en` (receive), `can0r_en` (receive), `spi_en` (MISO), then GPIO.
- R8: While `can0_en` is high, pin 1 drives `can0_tx` with `pad_oe`=1, and pin 0 is an input whose synchronized value appears on `can0_rx`. Otherwise both pins are GPIO.
- R9: A pin owned by a receive-type signal has `pad_oe`=0 and `pad_out`=0. A peripheral receive output whose pin is not owned by that peripheral reads 1.
- R10: Data latch writes land while a peripheral owns the pin. The written value appears on `pad_out` as soon as the pin returns to GPIO.
- R11: While SPI owns its pins, `spi_master`=1 makes MOSI (pin 4) and slave select (pin 5) outputs and MISO (pin 3) an input on `spi_miso_i`. `spi_master`=0 reverses all three: `spi_mosi_i` and `spi_ss_i` receive pins 4 and 5, and pin 3 drives `spi_miso_o`.
- R12: `can0r_rx` takes pin 4 when routed CAN0 owns pin 4, otherwise pin 3 when routed CAN0 owns pin 3, otherwise 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select: 0 data, 1 direction, 2 input, 3 none |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| pad_in | input | 8 | Raw pad input levels |
| pad_out | output | 8 | Pad output levels |
| pad_oe | output | 8 | Pad output enables |
| can0_en | input | 1 | Native CAN0 claims pins 1 and 0 |
| can0_tx | input | 1 | Native CAN0 transmit |
| can0_rx | output | 1 | Native CAN0 receive |
| can0r_en | input | 1 | Routed CAN0 claims pins 5, 4, 3 |
| can0r_tx | input | 1 | Routed CAN0 transmit |
| can0r_rx | output | 1 | Routed CAN0 receive |
| can1_en | input | 1 | CAN1 claims pins 5 and 3 |
| can1_tx | input | 1 | CAN1 transmit |
| can1_rx | output | 1 | CAN1 receive |
| can2_en | input | 1 | CAN2 receive claims pin 4 |
| can2_rx | output | 1 | CAN2 receive |
| can4r_en | input | 1 | Routed CAN4 receive claims pin 4 |
| can4r_rx | output | 1 | Routed CAN4 receive |
| spi_en | input | 1 | Routed SPI claims pins 5, 4, 3 |
| spi_master | input | 1 | SPI role: 1 master, 0 slave |
| spi_mosi_o | input | 1 | MOSI value driven by a master |
| spi_mosi_i | output | 1 | MOSI seen by a slave |
| spi_ss_o | input | 1 | Slave select driven by a master |
| spi_ss_i | output | 1 | Slave select seen by a slave |
| spi_miso_o | input | 1 | MISO value driven by a slave |
| spi_miso_i | output | 1 | MISO seen by a master |

## Verification
The arbitration is tried with every pattern of the six enables, so each precedence chain is seen with its winner alone and with every lower claimant also asserted. Lower-priority owners leaking through show up as a wrong owner on pins 3, 4 and 5. SPI role is toggled under those patterns, which separates drive from receive on the same pin. Register traffic with random direction masks and random pad levels separates the latch path from the synchronized path in the data read. Directed sequences cover writing under peripheral ownership, the two sources of the routed CAN0 receive, and idle receive levels.

// File: rtl/pmux_pkg.sv
package pmux_pkg;

    localparam int NPINS = 8;

    // pin positions that the ownership logic depends on
    localparam int P_C0RX = 0;
    localparam int P_C0TX = 1;
    localparam int P_MISO = 3;
    localparam int P_MOSI = 4;
    localparam int P_SS   = 5;

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_IN   = 2'd2,
        SEL_NONE = 2'd3
    } sel_e;

    typedef enum logic [2:0] {
        OWN_GPIO  = 3'd0,
        OWN_CAN0  = 3'd1,
        OWN_CAN0R = 3'd2,
        OWN_CAN1  = 3'd3,
        OWN_CAN2  = 3'd4,
        OWN_CAN4R = 3'd5,
        OWN_SPI   = 3'd6
    } own_e;

    typedef struct packed {
        logic can0;
        logic can0r;
        logic can1;
        logic can2;
        logic can4r;
        logic spi;
    } en_t;

    typedef struct packed {
        logic [NPINS-1:0] data;
        logic [NPINS-1:0] dir;
    } regs_t;

endpackage

// File: rtl/pmux_sync.sv
module pmux_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int k = 1; k < STAGES; k++) begin
            stg_d[k] = stg_q[k-1];
        end
    end

    // no reset: the synchronized pad state is unaffected by reset
    always_ff @(posedge clk) begin
        for (int k = 0; k < STAGES; k++) begin
            stg_q[k] <= stg_d[k];
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/pmux_regs.sv
module pmux_regs
    import pmux_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       sel,
    input  logic             wr,
    input  logic [NPINS-1:0] wdata,
    input  logic [NPINS-1:0] pin_sync,
    output logic [NPINS-1:0] rdata,
    output logic [NPINS-1:0] data_q,
    output logic [NPINS-1:0] dir_q
);

    regs_t regs_d;
    regs_t regs_q;
    sel_e  sel_v;

    assign sel_v = sel_e'(sel);

    always_comb begin
        regs_d = regs_q;
        if (wr) begin
            case (sel_v)
                SEL_DATA: regs_d.data = wdata;
                SEL_DIR:  regs_d.dir  = wdata;
                default:  regs_d      = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        case (sel_v)
            SEL_DATA: rdata = (regs_q.dir & regs_q.data) | (~regs_q.dir & pin_sync);
            SEL_DIR:  rdata = regs_q.dir;
            SEL_IN:   rdata = pin_sync;
            default:  rdata = '0;
        endcase
    end

    assign data_q = regs_q.data;
    assign dir_q  = regs_q.dir;

endmodule

// File: rtl/pmux_arb.sv
module pmux_arb
    import pmux_pkg::*;
(
    input  en_t  en,
    output own_e own [NPINS]
);

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        if (p == P_C0RX || p == P_C0TX) begin : g_can0
            assign own[p] = en.can0 ? OWN_CAN0 : OWN_GPIO;
        end else if (p == P_MISO) begin : g_miso
            always_comb begin
                if (en.can1)       own[p] = OWN_CAN1;
                else if (en.can0r) own[p] = OWN_CAN0R;
                else if (en.spi)   own[p] = OWN_SPI;
                else               own[p] = OWN_GPIO;
            end
        end else if (p == P_MOSI) begin : g_mosi
            always_comb begin
                if (en.can2)       own[p] = OWN_CAN2;
                else if (en.can0r) own[p] = OWN_CAN0R;
                else if (en.can4r) own[p] = OWN_CAN4R;
                else if (en.spi)   own[p] = OWN_SPI;
                else               own[p] = OWN_GPIO;
            end
        end else if (p == P_SS) begin : g_ss
            always_comb begin
                if (en.can1)       own[p] = OWN_CAN1;
                else if (en.can0r) own[p] = OWN_CAN0R;
                else if (en.spi)   own[p] = OWN_SPI;
                else               own[p] = OWN_GPIO;
            end
        end else begin : g_plain
            assign own[p] = OWN_GPIO;
        end
    end

endmodule

// File: rtl/pmux_pads.sv
module pmux_pads
    import pmux_pkg::*;
(
    input  own_e             own [NPINS],
    input  logic [NPINS-1:0] data_q,
    input  logic [NPINS-1:0] dir_q,
    input  logic [NPINS-1:0] pin_sync,
    input  logic             spi_master,
    input  logic             can0_tx,
    input  logic             can0r_tx,
    input  logic             can1_tx,
    input  logic             spi_mosi_o,
    input  logic             spi_ss_o,
    input  logic             spi_miso_o,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe,
    output logic             can0_rx,
    output logic             can0r_rx,
    output logic             can1_rx,
    output logic             can2_rx,
    output logic             can4r_rx,
    output logic             spi_mosi_i,
    output logic             spi_ss_i,
    output logic             spi_miso_i
);

    // pad drive: GPIO follows the registers, receive owners leave the pad at 0/0
    always_comb begin
        pad_out = '0;
        pad_oe  = '0;
        for (int i = 0; i < NPINS; i++) begin
            if (own[i] == OWN_GPIO) begin
                pad_out[i] = data_q[i];
                pad_oe[i]  = dir_q[i];
            end
        end
        if (own[P_C0TX] == OWN_CAN0) begin
            pad_out[P_C0TX] = can0_tx;
            pad_oe[P_C0TX]  = 1'b1;
        end
        if (own[P_MISO] == OWN_SPI && !spi_master) begin
            pad_out[P_MISO] = spi_miso_o;
            pad_oe[P_MISO]  = 1'b1;
        end
        if (own[P_MOSI] == OWN_SPI && spi_master) begin
            pad_out[P_MOSI] = spi_mosi_o;
            pad_oe[P_MOSI]  = 1'b1;
        end
        case (own[P_SS])
            OWN_CAN1: begin
                pad_out[P_SS] = can1_tx;
                pad_oe[P_SS]  = 1'b1;
            end
            OWN_CAN0R: begin
                pad_out[P_SS] = can0r_tx;
                pad_oe[P_SS]  = 1'b1;
            end
            OWN_SPI: begin
                if (spi_master) begin
                    pad_out[P_SS] = spi_ss_o;
                    pad_oe[P_SS]  = 1'b1;
                end
            end
            default: ;
        endcase
    end

    // receive routing: an unclaimed receive line idles high
    always_comb begin
        can0_rx    = (own[P_C0RX] == OWN_CAN0)  ? pin_sync[P_C0RX] : 1'b1;
        can1_rx    = (own[P_MISO] == OWN_CAN1)  ? pin_sync[P_MISO] : 1'b1;
        can2_rx    = (own[P_MOSI] == OWN_CAN2)  ? pin_sync[P_MOSI] : 1'b1;
        can4r_rx   = (own[P_MOSI] == OWN_CAN4R) ? pin_sync[P_MOSI] : 1'b1;
        spi_miso_i = (own[P_MISO] == OWN_SPI && spi_master)  ? pin_sync[P_MISO] : 1'b1;
        spi_mosi_i = (own[P_MOSI] == OWN_SPI && !spi_master) ? pin_sync[P_MOSI] : 1'b1;
        spi_ss_i   = (own[P_SS]   == OWN_SPI && !spi_master) ? pin_sync[P_SS]   : 1'b1;
        if (own[P_MOSI] == OWN_CAN0R) begin
            can0r_rx = pin_sync[P_MOSI];
        end else if (own[P_MISO] == OWN_CAN0R) begin
            can0r_rx = pin_sync[P_MISO];
        end else begin
            can0r_rx = 1'b1;
        end
    end

endmodule

// File: rtl/pmux_port.sv
module pmux_port
    import pmux_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       reg_sel,
    input  logic             reg_wr,
    input  logic [NPINS-1:0] reg_wdata,
    output logic [NPINS-1:0] reg_rdata,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe,
    input  logic             can0_en,
    input  logic             can0_tx,
    output logic             can0_rx,
    input  logic             can0r_en,
    input  logic             can0r_tx,
    output logic             can0r_rx,
    input  logic             can1_en,
    input  logic             can1_tx,
    output logic             can1_rx,
    input  logic             can2_en,
    output logic             can2_rx,
    input  logic             can4r_en,
    output logic             can4r_rx,
    input  logic             spi_en,
    input  logic             spi_master,
    input  logic             spi_mosi_o,
    output logic             spi_mosi_i,
    input  logic             spi_ss_o,
    output logic             spi_ss_i,
    input  logic             spi_miso_o,
    output logic             spi_miso_i
);

    logic [NPINS-1:0] pin_sync;
    logic [NPINS-1:0] data_q;
    logic [NPINS-1:0] dir_q;
    en_t              en;
    own_e             own [NPINS];

    assign en = '{can0: can0_en, can0r: can0r_en, can1: can1_en,
                  can2: can2_en, can4r: can4r_en, spi: spi_en};

    pmux_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .din  (pad_in),
        .dout (pin_sync)
    );

    pmux_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (reg_sel),
        .wr       (reg_wr),
        .wdata    (reg_wdata),
        .pin_sync (pin_sync),
        .rdata    (reg_rdata),
        .data_q   (data_q),
        .dir_q    (dir_q)
    );

    pmux_arb u_arb (
        .en  (en),
        .own (own)
    );

    pmux_pads u_pads (
        .own        (own),
        .data_q     (data_q),
        .dir_q      (dir_q),
        .pin_sync   (pin_sync),
        .spi_master (spi_master),
        .can0_tx    (can0_tx),
        .can0r_tx   (can0r_tx),
        .can1_tx    (can1_tx),
        .spi_mosi_o (spi_mosi_o),
        .spi_ss_o   (spi_ss_o),
        .spi_miso_o (spi_miso_o),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe),
        .can0_rx    (can0_rx),
        .can0r_rx   (can0r_rx),
        .can1_rx    (can1_rx),
        .can2_rx    (can2_rx),
        .can4r_rx   (can4r_rx),
        .spi_mosi_i (spi_mosi_i),
        .spi_ss_i   (spi_ss_i),
        .spi_miso_i (spi_miso_i)
    );

endmodule

// File: rtl/pmux_port_chk.sv
module pmux_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] reg_sel,
    input logic       reg_wr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic [7:0] pad_in,
    input logic [7:0] pad_out,
    input logic [7:0] pad_oe,
    input logic       can0_en,
    input logic       can0_tx,
    input logic       can1_en,
    input logic       can1_tx,
    input logic       can1_rx,
    input logic       can2_en,
    input logic       can2_rx
);

    // edges seen since time zero, saturating; guards pad history lookups
    logic [1:0] warm_q = 2'd0;
    always_ff @(posedge clk) begin
        if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end

    assert_dir_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (reg_sel != 2'd1 || reg_rdata == 8'h00));

    assert_gpio_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd1) |=> pad_oe[7] == $past(reg_wdata[7]));

    assert_input_reg_R4: assert property (@(posedge clk)
        (reg_sel == 2'd2 && warm_q >= 2'd2) |-> reg_rdata == $past(pad_in, 2));

    assert_pin4_can2_R5: assert property (@(posedge clk) disable iff (!rst_n)
        can2_en |-> !pad_oe[4] && !pad_out[4]);

    assert_pin5_can1_R6: assert property (@(posedge clk) disable iff (!rst_n)
        can1_en |-> pad_oe[5] && pad_out[5] == can1_tx);

    assert_pin3_can1_R7: assert property (@(posedge clk)
        (can1_en && warm_q >= 2'd2) |-> !pad_oe[3] && can1_rx == $past(pad_in[3], 2));

    assert_can0_pins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        can0_en |-> pad_oe[1] && pad_out[1] == can0_tx && !pad_oe[0]);

    assert_idle_rx_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !can2_en |-> can2_rx);

endmodule

bind pmux_port pmux_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_sel   (reg_sel),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .can0_en   (can0_en),
    .can0_tx   (can0_tx),
    .can1_en   (can1_en),
    .can1_tx   (can1_tx),
    .can1_rx   (can1_rx),
    .can2_en   (can2_en),
    .can2_rx   (can2_rx)
);

// File: tb/pmux_port_test.sv
module pmux_port_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] reg_sel = '0;
    logic reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_out, pad_oe;
    logic can0_en = 0, can0_tx = 0, can0r_en = 0, can0r_tx = 0, can1_en = 0, can1_tx = 0;
    logic can2_en = 0, can4r_en = 0, spi_en = 0, spi_master = 0;
    logic spi_mosi_o = 0, spi_ss_o = 0, spi_miso_o = 0;
    logic can0_rx, can0r_rx, can1_rx, can2_rx, can4r_rx, spi_mosi_i, spi_ss_i, spi_miso_i;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference state
    logic [7:0] m_data, m_dir;
    logic [7:0] pipe[$];

    always #10 clk = ~clk;

    pmux_port uut (.*);

    task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
        end
    endtask

    function automatic string pin_tag(int b);
        case (b)
            0, 1: return "R8";
            3: return "R7";
            4: return "R5";
            5: return "R6";
            default: return "R2";
        endcase
    endfunction

    task automatic model_edge();
        pipe.push_back(pad_in);
        if (pipe.size() > 2) void'(pipe.pop_front());
        if (!rst_n) begin
            m_data = 8'h00;
            m_dir  = 8'h00;
        end else if (reg_wr) begin
            if (reg_sel == 2'd0) m_data = reg_wdata;
            if (reg_sel == 2'd1) m_dir = reg_wdata;
        end
    endtask

    task automatic compare_all();
        logic [7:0] s, e_out, e_oe, e_rd;
        logic [7:0] e_rx, a_rx;
        string who3, who4, who5;
        if (!rst_n || pipe.size() < 2) return;
        s = pipe[0];
        e_out = m_data;
        e_oe = m_dir;
        // receive order: can0, can0r, can1, can2, can4r, mosi_i, miso_i, ss_i
        e_rx = 8'hFF;
        if (can0_en) begin
            e_out[1] = can0_tx; e_oe[1] = 1;
            e_out[0] = 0; e_oe[0] = 0; e_rx[7] = s[0];
        end
        who3 = can1_en ? "can1" : can0r_en ? "can0r" : spi_en ? "spi" : "gpio";
        who4 = can2_en ? "can2" : can0r_en ? "can0r" : can4r_en ? "can4r" : spi_en ? "spi" : "gpio";
        who5 = can1_en ? "can1" : can0r_en ? "can0r" : spi_en ? "spi" : "gpio";
        if (who3 != "gpio") begin e_out[3] = 0; e_oe[3] = 0; end
        if (who4 != "gpio") begin e_out[4] = 0; e_oe[4] = 0; end
        if (who5 != "gpio") begin e_out[5] = 0; e_oe[5] = 0; end
        if (who3 == "can1") e_rx[5] = s[3];
        if (who3 == "spi") begin
            if (spi_master) e_rx[1] = s[3];
            else begin e_out[3] = spi_miso_o; e_oe[3] = 1; end
        end
        if (who4 == "can2") e_rx[4] = s[4];
        if (who4 == "can4r") e_rx[3] = s[4];
        if (who4 == "spi") begin
            if (spi_master) begin e_out[4] = spi_mosi_o; e_oe[4] = 1; end
            else e_rx[2] = s[4];
        end
        if (who5 == "can1") begin e_out[5] = can1_tx; e_oe[5] = 1; end
        if (who5 == "can0r") begin e_out[5] = can0r_tx; e_oe[5] = 1; end
        if (who5 == "spi") begin
            if (spi_master) begin e_out[5] = spi_ss_o; e_oe[5] = 1; end
            else e_rx[0] = s[5];
        end
        if (who4 == "can0r") e_rx[6] = s[4];
        else if (who3 == "can0r") e_rx[6] = s[3];
        for (int b = 0; b < 8; b++) begin
            chk(pin_tag(b), $sformatf("pad_out[%0d]", b), {7'd0, pad_out[b]}, {7'd0, e_out[b]});
            chk(pin_tag(b), $sformatf("pad_oe[%0d]", b), {7'd0, pad_oe[b]}, {7'd0, e_oe[b]});
        end
        case (reg_sel)
            2'd0: begin e_rd = (m_dir & m_data) | (~m_dir & s); chk("R3", "data read", reg_rdata, e_rd); end
            2'd1: chk("R2", "direction read", reg_rdata, m_dir);
            2'd2: chk("R4", "input read", reg_rdata, s);
            default: chk("R3", "empty select read", reg_rdata, 8'h00);
        endcase
        a_rx = {can0_rx, can0r_rx, can1_rx, can2_rx, can4r_rx, spi_mosi_i, spi_miso_i, spi_ss_i};
        chk("R8", "can0_rx", {7'd0, a_rx[7]}, {7'd0, e_rx[7]});
        chk("R12", "can0r_rx", {7'd0, a_rx[6]}, {7'd0, e_rx[6]});
        chk("R7", "can1_rx", {7'd0, a_rx[5]}, {7'd0, e_rx[5]});
        chk("R5", "can2/can4r rx", {6'd0, a_rx[4:3]}, {6'd0, e_rx[4:3]});
        chk("R11", "spi inputs", {5'd0, a_rx[2:0]}, {5'd0, e_rx[2:0]});
    endtask

    task automatic cycle();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    task automatic write_reg(logic [1:0] sel, logic [7:0] val);
        reg_sel = sel; reg_wr = 1; reg_wdata = val;
        cycle();
        reg_wr = 0;
    endtask

    task automatic all_off();
        {can0_en, can0r_en, can1_en, can2_en, can4r_en, spi_en} = '0;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        pad_in = 8'h5A;
        repeat (3) cycle();
        rst_n = 1;
        reg_sel = 2'd1;
        cycle();
        // R1: reset state of direction and output enables
        chk("R1", "direction after reset", reg_rdata, 8'h00);
        chk("R1", "pad_oe after reset", pad_oe, 8'h00);

        // R4: writes to the input select do nothing; R9: idle receive lines
        write_reg(2'd2, 8'hFF);
        write_reg(2'd3, 8'hFF);
        reg_sel = 2'd1;
        cycle();
        chk("R4", "direction after input-select write", reg_rdata, 8'h00);
        chk("R9", "idle receive lines", {can0_rx, can0r_rx, can1_rx, can2_rx, can4r_rx, spi_mosi_i, spi_miso_i, spi_ss_i}, 8'hFF);

        // plain GPIO traffic
        for (int n = 0; n < 400; n++) begin
            reg_sel = 2'($urandom);
            reg_wr = ($urandom % 3) == 0;
            reg_wdata = 8'($urandom);
            pad_in = 8'($urandom);
            cycle();
        end

        // every enable pattern with random traffic
        for (int n = 0; n < 4000; n++) begin
            {can0_en, can0r_en, can1_en, can2_en, can4r_en, spi_en} = 6'(n % 64);
            if (n % 7 == 0) {can0_en, can0r_en, can1_en, can2_en, can4r_en, spi_en} = 6'($urandom);
            spi_master = 1'($urandom);
            {can0_tx, can0r_tx, can1_tx, spi_mosi_o, spi_ss_o, spi_miso_o} = 6'($urandom);
            reg_sel = 2'($urandom);
            reg_wr = ($urandom % 4) == 0;
            reg_wdata = 8'($urandom);
            pad_in = 8'($urandom);
            cycle();
        end
        reg_wr = 0;

        // R10: latch write while CAN1 owns pin 5, visible after release
        all_off();
        write_reg(2'd1, 8'hFF);
        write_reg(2'd0, 8'h00);
        can1_en = 1; can1_tx = 0;
        write_reg(2'd0, 8'h20);
        reg_sel = 2'd0;
        cycle();
        chk("R10", "pin 5 while owned", {7'd0, pad_out[5]}, 8'h00);
        can1_en = 0;
        cycle();
        chk("R10", "pin 5 after release", {7'd0, pad_out[5]}, 8'h01);
        chk("R10", "latch read back", reg_rdata, 8'h20);

        // R12: routed CAN0 receive falls to pin 3 when CAN2 holds pin 4
        all_off();
        can0r_en = 1; can2_en = 1;
        pad_in = 8'h08;
        cycle(); cycle();
        chk("R12", "can0r_rx from pin 3", {7'd0, can0r_rx}, 8'h01);
        can2_en = 0;
        cycle();
        chk("R12", "can0r_rx from pin 4", {7'd0, can0r_rx}, 8'h00);

        // R11: slave role drives MISO on pin 3
        all_off();
        spi_en = 1; spi_master = 0; spi_miso_o = 1;
        cycle();
        chk("R11", "slave MISO drive", {6'd0, pad_oe[3], pad_out[3]}, 8'h03);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule